// File: doc/BRIEF.md
# Multi-event clock domain crossing

This block carries one-cycle event strobes from a fast source clock into a slower destination clock without dropping any of them. The intended pairing is a 50 MHz source feeding a 20 MHz destination. In that pairing, strobes can arrive on every second source cycle, which is faster than the destination can emit one strobe per cycle. The block therefore counts events instead of forwarding them one by one.

The source side keeps a binary event count and registers its Gray-coded form. That Gray value is resynchronised in the destination domain and decoded back to binary. A replay counter in the destination domain trails the synchronised count. Whenever the two differ, the block emits one output strobe per destination cycle and advances the replay counter, so a backlog drains as a run of back-to-back high cycles.

Each destination cycle in which `dst_evt` is high stands for exactly one source event. The counter width sets how large a backlog can be held. The default width holds more than 64 pending events. A sticky flag warns when the visible backlog comes near that capacity.

Top module: `evt_xfer_top`

## Requirements
- R1: While `dst_rst_n` is low, `dst_evt` and `dst_ovf` are low. After both resets are released and with no input events, they stay low.
- R2: With `src_evt` held low, no destination strobe is ever produced.
- R3: After the input has been idle long enough to drain, the number of destination cycles with `dst_evt` high equals the number of source cycles with `src_evt` high since reset, provided `dst_ovf` stayed low.
- R4: A backlog of more than one event is emitted on consecutive destination cycles, one event per cycle.
- R5: An isolated event arriving on an idle block shows up on `dst_evt` between 2 and 6 destination cycles later.
- R6: `dst_ovf` rises on the cycle after the backlog seen in the destination domain reaches 2^CNT_W − 8. A burst whose backlog stays below that value leaves `dst_ovf` low.
- R7: Once set, `dst_ovf` stays high until `dst_rst_n` is driven low.
- R8: Events spaced as closely as every second source cycle are each counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source-domain clock |
| src_rst_n | input | 1 | Source-domain reset, asynchronous assert, active low |
| src_evt | input | 1 | One-cycle event strobe, source domain |
| dst_clk | input | 1 | Destination-domain clock |
| dst_rst_n | input | 1 | Destination-domain reset, asynchronous assert, active low |
| dst_evt | output | 1 | One event per high cycle, destination domain |
| dst_ovf | output | 1 | Sticky warning that the backlog neared capacity |

## Verification
The hardest state to reach from the ports is a backlog that climbs to the warning threshold. Only a long, sustained burst at peak rate builds such a backlog, and each event adds just a fifth of a destination cycle of lag.

The bench uses a 5-bit counter, which puts the threshold at 24. It drives 150 events spaced two source cycles apart, against a destination clock 2.5 times slower, so the backlog grows to about 30. It also sweeps shorter bursts across several spacings, and these must stay below the threshold. After each burst it compares the replayed total with the number of events sent.

// File: rtl/evt_xfer_pkg.sv
package evt_xfer_pkg;

  // default depth of every two-flop style synchroniser in the block
  localparam int unsigned XFER_SYNC_STAGES = 2;

  // headroom kept between the warning threshold and the counter wrap;
  // covers events still travelling through the crossing registers
  localparam int unsigned XFER_LAG_MARGIN = 8;

  function automatic int unsigned backlog_limit(input int unsigned w);
    return (1 << w) - XFER_LAG_MARGIN;
  endfunction

endpackage

// File: rtl/evt_rst_sync.sv
module evt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/evt_src_count.sv
module evt_src_count #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_i,
  output logic [CNT_W-1:0] gray_o
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] bin_q;
  logic [CNT_W-1:0] bin_d;
  logic [CNT_W-1:0] gray_q;
  logic [CNT_W-1:0] gray_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = evt_i;
    bin_d  = bin_q + ONE;
    gray_d = bin_d ^ (bin_d >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else if (cnt_en) begin
      bin_q  <= bin_d;
      gray_q <= gray_d;
    end
  end

  assign gray_o = gray_q;

endmodule

// File: rtl/evt_gray_sync.sv
module evt_gray_sync #(
  parameter int unsigned CNT_W  = 7,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] gray_i,
  output logic [CNT_W-1:0] bin_o
);

  logic [STAGES-1:0][CNT_W-1:0] stage_q;
  logic [STAGES-1:0][CNT_W-1:0] stage_d;
  logic [CNT_W-1:0]             gray_s;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], gray_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign gray_s = stage_q[STAGES-1];

  // each binary bit is the parity of the Gray bits at and above it
  for (genvar i = 0; i < CNT_W; i++) begin : g_decode
    assign bin_o[i] = ^gray_s[CNT_W-1:i];
  end

endmodule

// File: rtl/evt_dst_replay.sv
module evt_dst_replay #(
  parameter int unsigned CNT_W   = 7,
  parameter int unsigned OVF_LIM = 120
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] sync_bin_i,
  output logic             evt_o,
  output logic             ovf_o,
  output logic [CNT_W-1:0] backlog_o,
  output logic [CNT_W-1:0] replay_o
);

  localparam logic [CNT_W-1:0] LIM_V = CNT_W'(OVF_LIM);
  localparam logic [CNT_W-1:0] ONE   = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] replay_q;
  logic [CNT_W-1:0] replay_d;
  logic [CNT_W-1:0] backlog;
  logic             pend;
  logic             at_limit;
  logic             evt_q;
  logic             evt_d;
  logic             ovf_q;
  logic             ovf_d;

  always_comb begin
    backlog  = sync_bin_i - replay_q;
    pend     = (backlog != '0);
    at_limit = (backlog >= LIM_V);
    evt_d    = pend;
    replay_d = pend ? (replay_q + ONE) : replay_q;
    ovf_d    = ovf_q | at_limit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      replay_q <= '0;
      evt_q    <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      replay_q <= replay_d;
      evt_q    <= evt_d;
      ovf_q    <= ovf_d;
    end
  end

  assign evt_o     = evt_q;
  assign ovf_o     = ovf_q;
  assign backlog_o = backlog;
  assign replay_o  = replay_q;

endmodule

// File: rtl/evt_xfer_top.sv
module evt_xfer_top #(
  parameter int unsigned CNT_W       = 7,
  parameter int unsigned SYNC_STAGES = evt_xfer_pkg::XFER_SYNC_STAGES
) (
  input  logic src_clk,
  input  logic src_rst_n,
  input  logic src_evt,
  input  logic dst_clk,
  input  logic dst_rst_n,
  output logic dst_evt,
  output logic dst_ovf
);

  localparam int unsigned OVF_LIM = evt_xfer_pkg::backlog_limit(CNT_W);

  logic             src_rst_s;
  logic             dst_rst_s;
  logic [CNT_W-1:0] src_gray;
  logic [CNT_W-1:0] sync_bin;
  logic [CNT_W-1:0] backlog;
  logic [CNT_W-1:0] replay_cnt;

  evt_rst_sync #(.STAGES(SYNC_STAGES)) u_src_rst (
    .clk     (src_clk),
    .arst_n  (src_rst_n),
    .rst_n_o (src_rst_s)
  );

  evt_rst_sync #(.STAGES(SYNC_STAGES)) u_dst_rst (
    .clk     (dst_clk),
    .arst_n  (dst_rst_n),
    .rst_n_o (dst_rst_s)
  );

  evt_src_count #(.CNT_W(CNT_W)) u_src (
    .clk    (src_clk),
    .rst_n  (src_rst_s),
    .evt_i  (src_evt),
    .gray_o (src_gray)
  );

  evt_gray_sync #(.CNT_W(CNT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (dst_clk),
    .rst_n  (dst_rst_s),
    .gray_i (src_gray),
    .bin_o  (sync_bin)
  );

  evt_dst_replay #(.CNT_W(CNT_W), .OVF_LIM(OVF_LIM)) u_replay (
    .clk        (dst_clk),
    .rst_n      (dst_rst_s),
    .sync_bin_i (sync_bin),
    .evt_o      (dst_evt),
    .ovf_o      (dst_ovf),
    .backlog_o  (backlog),
    .replay_o   (replay_cnt)
  );

endmodule

// File: rtl/evt_xfer_chk.sv
module evt_xfer_chk #(
  parameter int unsigned CNT_W = 7
) (
  input logic             src_clk,
  input logic             src_rst_s,
  input logic [CNT_W-1:0] src_gray,
  input logic             dst_clk,
  input logic             dst_rst_s,
  input logic [CNT_W-1:0] sync_bin,
  input logic [CNT_W-1:0] replay_cnt,
  input logic [CNT_W-1:0] backlog,
  input logic             dst_evt,
  input logic             dst_ovf
);

  localparam logic [CNT_W-1:0] LIM_V  = CNT_W'(evt_xfer_pkg::backlog_limit(CNT_W));
  localparam logic [CNT_W-1:0] HALF_V = CNT_W'(1 << (CNT_W - 1));
  localparam logic [CNT_W-1:0] ONE_V  = {{(CNT_W-1){1'b0}}, 1'b1};

  AST_GRAY_ONE_STEP: assert property (@(posedge src_clk) disable iff (!src_rst_s)
    $countones(src_gray ^ $past(src_gray)) <= 1); // R3

  AST_SYNC_MONOTONIC: assert property (@(posedge dst_clk) disable iff (!dst_rst_s)
    CNT_W'(sync_bin - $past(sync_bin)) < HALF_V); // R3

  AST_REPLAY_STEP: assert property (@(posedge dst_clk) disable iff (!dst_rst_s)
    CNT_W'(replay_cnt - $past(replay_cnt)) <= ONE_V); // R4

  AST_EVT_MATCHES_STEP: assert property (@(posedge dst_clk) disable iff (!dst_rst_s)
    dst_evt == (replay_cnt != $past(replay_cnt))); // R4

  AST_OVF_AT_LIMIT: assert property (@(posedge dst_clk) disable iff (!dst_rst_s)
    (backlog >= LIM_V) |=> dst_ovf); // R6

  AST_OVF_STICKY: assert property (@(posedge dst_clk) disable iff (!dst_rst_s)
    dst_ovf |=> dst_ovf); // R7

endmodule

bind evt_xfer_top evt_xfer_chk #(.CNT_W(CNT_W)) u_chk (
  .src_clk    (src_clk),
  .src_rst_s  (src_rst_s),
  .src_gray   (src_gray),
  .dst_clk    (dst_clk),
  .dst_rst_s  (dst_rst_s),
  .sync_bin   (sync_bin),
  .replay_cnt (replay_cnt),
  .backlog    (backlog),
  .dst_evt    (dst_evt),
  .dst_ovf    (dst_ovf)
);

// File: tb/tb_evt_xfer_top.sv
module tb_evt_xfer_top;

  localparam int unsigned W = 5;
  localparam int LIMIT = (2 ** W) - 8;  // 24: warning threshold

  logic src_clk = 1'b0;
  logic dst_clk = 1'b0;
  logic src_rst_n;
  logic dst_rst_n;
  logic src_evt;
  logic dst_evt;
  logic dst_ovf;

  int n_chk   = 0;
  int n_fail  = 0;
  int out_cnt = 0;
  int run     = 0;
  int max_run = 0;
  bit done    = 1'b0;

  always #4  src_clk = ~src_clk;  // 125 MHz source
  always #10 dst_clk = ~dst_clk;  // 50 MHz destination, 2.5x slower

  evt_xfer_top #(.CNT_W(W)) dut (
    .src_clk   (src_clk),
    .src_rst_n (src_rst_n),
    .src_evt   (src_evt),
    .dst_clk   (dst_clk),
    .dst_rst_n (dst_rst_n),
    .dst_evt   (dst_evt),
    .dst_ovf   (dst_ovf)
  );

  always @(negedge dst_clk) begin
    if (dst_evt) begin
      out_cnt = out_cnt + 1;
      run = run + 1;
      if (run > max_run) max_run = run;
    end else begin
      run = 0;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input int n, input int gap);
    for (int k = 0; k < n; k++) begin
      @(negedge src_clk) src_evt = 1'b1;
      @(negedge src_clk) src_evt = 1'b0;
      repeat (gap - 2) @(negedge src_clk);
    end
  endtask

  task automatic settle(input int k);
    repeat (k) @(negedge dst_clk);
  endtask

  initial begin
    int gaps [5];
    int lens [5];
    int base;
    int lat;
    gaps = '{2, 3, 4, 6, 9};
    lens = '{1, 2, 5, 17, 60};
    src_evt   = 1'b0;
    src_rst_n = 1'b0;
    dst_rst_n = 1'b0;
    settle(5);
    check(dst_evt == 1'b0, "R1 dst_evt in reset", int'(dst_evt), 0);
    check(dst_ovf == 1'b0, "R1 dst_ovf in reset", int'(dst_ovf), 0);
    src_rst_n = 1'b1;
    dst_rst_n = 1'b1;
    settle(30);
    check(out_cnt == 0, "R2 idle produces no strobe", out_cnt, 0);
    check(dst_ovf == 1'b0, "R1 dst_ovf after release", int'(dst_ovf), 0);

    // isolated event latency
    base = out_cnt;
    @(negedge src_clk) src_evt = 1'b1;
    @(negedge src_clk) src_evt = 1'b0;
    lat = 0;
    while (lat < 20) begin
      @(negedge dst_clk);
      lat++;
      if (dst_evt) break;
    end
    check(lat >= 2 && lat <= 6, "R5 isolated latency", lat, 4);
    settle(10);
    check(out_cnt - base == 1, "R3 isolated count", out_cnt - base, 1);

    // sweep of spacings and burst lengths, all below the threshold
    foreach (gaps[g]) begin
      foreach (lens[l]) begin
        base = out_cnt;
        @(negedge dst_clk);
        #1 max_run = 0;
        send(lens[l], gaps[g]);
        settle(lens[l] + 25);
        if (gaps[g] == 2)
          check(out_cnt - base == lens[l], "R8 peak-rate burst count", out_cnt - base, lens[l]);
        else
          check(out_cnt - base == lens[l], "R3 burst count", out_cnt - base, lens[l]);
        check(dst_ovf == 1'b0, "R6 no warning below threshold", int'(dst_ovf), 0);
        if (gaps[g] == 2 && lens[l] == 60)
          check(max_run >= 2, "R4 back-to-back drain", max_run, 2);
      end
    end

    // sustained peak burst drives the backlog past LIMIT
    send(150, 2);
    settle(60);
    check(dst_ovf == 1'b1, $sformatf("R6 warning at backlog %0d", LIMIT), int'(dst_ovf), 1);
    settle(40);
    check(dst_ovf == 1'b1, "R7 warning stays set", int'(dst_ovf), 1);
    src_rst_n = 1'b0;
    dst_rst_n = 1'b0;
    settle(3);
    check(dst_ovf == 1'b0, "R7 warning cleared by reset", int'(dst_ovf), 0);
    check(dst_evt == 1'b0, "R1 dst_evt in second reset", int'(dst_evt), 0);
    src_rst_n = 1'b1;
    dst_rst_n = 1'b1;
    settle(10);
    base = out_cnt;
    send(5, 3);
    settle(30);
    check(out_cnt - base == 5, "R3 count after recovery", out_cnt - base, 5);
    check(dst_ovf == 1'b0, "R7 warning stays clear", int'(dst_ovf), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule